// File: doc/BRIEF.md
# Timed Page-Buffer Write Controller

This block sits behind an asynchronous memory-style host bus (active-low chip enable, write enable and output enable) and gathers byte writes into a 128-byte page buffer before committing them to a behavioural nonvolatile array model. The strobes are sampled in the block's clock domain. The block captures an address when the second of chip enable and write enable goes low, and it captures a data byte when the first of them goes high. A separate input carries the unlock decision for the write. When that input is low, byte loads are dropped.

Each accepted byte re-arms a load-window timer. If no further byte arrives within the window, the block starts a fixed-length program cycle. That cycle cannot be interrupted. At its end the whole page is written to the array in one step: bytes that were loaded keep their data and every other location receives 0xFF. The target page is the page address of the most recently loaded byte. From the first load until the commit, reads return a status byte and not array contents. All times are clock-cycle counts given as parameters.

Top module: `pgw_ctrl_top`

## Requirements
- R1: The address is captured on the clock edge where chip enable and write enable are first both seen low. Its bits 16..7 form the page address and bits 6..0 the byte offset.
- R2: A byte is loaded on the clock edge where that joint-low condition first ends. The data is taken from `dq_i` and stored at the captured offset.
- R3: A second load to an offset already loaded in the same page load replaces the earlier byte.
- R4: The page committed is the page address of the last accepted byte. Bytes loaded earlier under another page address go to that last page at their own offsets.
- R5: Every offset not loaded since the page load began is committed as 0xFF. Each page load starts from an empty buffer.
- R6: Each accepted load restarts the window. The program cycle begins `LOAD_TIMEOUT` clock edges after the last load edge if no other load is accepted in that time.
- R7: The program cycle lasts `PROG_CYCLES` edges and then commits the page. The block then becomes idle `LOAD_TIMEOUT+PROG_CYCLES` edges after the last load. Loads offered during the program cycle are ignored.
- R8: `dq_en` is 1 only while both `ce_n` and `oe_n` are low. Otherwise `dq_en` is 0 and `dq_o` is 0.
- R9: From the first load until the commit, a read returns a status byte. Bit 7 is the complement of bit 7 of the last accepted byte, bit 6 is a toggle that inverts after every read, and bits 5..0 are 0.
- R10: While `wr_unlock` is low, byte loads are ignored and do not start a write.
- R11: After reset the block is idle and every array location reads 0xFF. When idle, a read returns the array byte at `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; page in the upper bits, offset in the low 7 |
| dq_i | input | 8 | Write data from the host |
| wr_unlock | input | 1 | Unlock decision; loads are accepted only while high |
| dq_o | output | 8 | Read data or status byte |
| dq_en | output | 1 | Output drive enable for the data bus |

## Verification
An address is captured on the first clock edge that sees both enables low. The byte lands in the buffer on the edge after write enable rises, and that edge is edge zero of the load window. The status byte changes to array data exactly on edge `LOAD_TIMEOUT+PROG_CYCLES`. The bench drives strobes on falling clock edges and counts rising edges from the return of the last load. It reads once while the state after edge `LOAD_TIMEOUT+PROG_CYCLES-1` is visible and once after the commit edge. It samples the combinational read path 1 ns after a falling edge, before the toggle update on the next rising edge. Each read pushes its expected byte and enable into a queue, and a monitor pops and compares them in order.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pgw_state_e;
endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              load_p,
   output logic              rd_p
);
   logic wsel_now, wsel_q, rsel_now, rsel_q;

   assign wsel_now = ~ce_n & ~we_n;
   assign rsel_now = ~ce_n & ~oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsel_q   <= 1'b0;
         rsel_q   <= 1'b0;
         addr_lat <= '0;
      end else begin
         wsel_q <= wsel_now;
         rsel_q <= rsel_now;
         if (wsel_now && !wsel_q) addr_lat <= addr;
      end
   end

   assign load_p = wsel_q & ~wsel_now;
   assign rd_p   = rsel_now & ~rsel_q;
endmodule

// File: rtl/pgw_timer_ctrl.sv
module pgw_timer_ctrl #(
   parameter int LOAD_TIMEOUT = 40000,
   parameter int PROG_CYCLES  = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_p,
   input  logic              rd_p,
   input  logic              unlock,
   output pgw_pkg::pgw_state_e state,
   output logic              load_acc,
   output logic              page_start,
   output logic              commit_p,
   output logic              toggle
);
   import pgw_pkg::*;
   localparam int LW = $clog2(LOAD_TIMEOUT + 1);
   localparam int PW = $clog2(PROG_CYCLES + 1);
   localparam logic [LW-1:0] LT_LAST = LW'(LOAD_TIMEOUT - 1);
   localparam logic [PW-1:0] PC_LAST = PW'(PROG_CYCLES - 1);

   logic [LW-1:0] win_cnt;
   logic [PW-1:0] prog_cnt;

   assign load_acc   = load_p & unlock & (state != ST_PROG);
   assign page_start = load_acc & (state == ST_IDLE);
   assign commit_p   = (state == ST_PROG) && (prog_cnt == PC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         win_cnt  <= '0;
         prog_cnt <= '0;
         toggle   <= 1'b0;
      end else begin
         if (rd_p && state != ST_IDLE) toggle <= ~toggle;
         unique case (state)
            ST_IDLE: if (load_acc) begin
               state   <= ST_LOAD;
               win_cnt <= '0;
            end
            ST_LOAD: begin
               if (load_acc) win_cnt <= '0;
               else if (win_cnt == LT_LAST) begin
                  state    <= ST_PROG;
                  prog_cnt <= '0;
               end else win_cnt <= win_cnt + 1'b1;
            end
            ST_PROG: begin
               if (commit_p) state <= ST_IDLE;
               else prog_cnt <= prog_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
   parameter int PAGE_BYTES = 128,
   parameter int PAGE_W     = 10,
   parameter bit USE_MASK   = 1'b1,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic                    start,
   input  logic [OFF_W-1:0]        off,
   input  logic [PAGE_W-1:0]       page_in,
   input  logic [7:0]              din,
   output logic [PAGE_W-1:0]       page_q,
   output logic                    last_d7,
   output logic [PAGE_BYTES*8-1:0] page_flat
);
   logic [7:0]            bytes_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'hFF;
         mask_q  <= '0;
         page_q  <= '0;
         last_d7 <= 1'b0;
      end else if (wr) begin
         if (start) for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'hFF;
         bytes_q[off] <= din;
         mask_q  <= (start ? '0 : mask_q) | (PAGE_BYTES'(1) << off);
         page_q  <= page_in;
         last_d7 <= din[7];
      end
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
      if (USE_MASK) begin : g_masked
         assign page_flat[g*8 +: 8] = mask_q[g] ? bytes_q[g] : 8'hFF;
      end else begin : g_raw
         assign page_flat[g*8 +: 8] = bytes_q[g];
      end
   end
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
   parameter int PAGE_BYTES  = 128,
   parameter int MODEL_PAGES = 4,
   localparam int OFF_W      = $clog2(PAGE_BYTES),
   localparam int MIDX_W     = $clog2(MODEL_PAGES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [MIDX_W-1:0]       wr_page,
   input  logic [PAGE_BYTES*8-1:0] page_flat,
   input  logic [MIDX_W-1:0]       rd_page,
   input  logic [OFF_W-1:0]        rd_off,
   output logic [7:0]              rd_data
);
   localparam int DEPTH = MODEL_PAGES * PAGE_BYTES;
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++)
            mem[{wr_page, OFF_W'(i)}] <= page_flat[i*8 +: 8];
      end
   end

   assign rd_data = mem[{rd_page, rd_off}];
endmodule

// File: rtl/pgw_ctrl_top.sv
module pgw_ctrl_top #(
   parameter int ADDR_W       = 17,
   parameter int PAGE_BYTES   = 128,
   parameter int MODEL_PAGES  = 4,
   parameter int LOAD_TIMEOUT = 40000,
   parameter int PROG_CYCLES  = 1000000,
   parameter bit USE_MASK     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_i,
   input  logic              wr_unlock,
   output logic [7:0]        dq_o,
   output logic              dq_en
);
   import pgw_pkg::*;
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int MIDX_W = $clog2(MODEL_PAGES);

   if (PAGE_BYTES != (1 << OFF_W)) begin : g_chk_pow2
      $error("PAGE_BYTES must be a power of two");
   end
   if (MODEL_PAGES < 2 || MIDX_W > PAGE_W) begin : g_chk_model
      $error("MODEL_PAGES out of range");
   end
   if (LOAD_TIMEOUT < 2 || PROG_CYCLES < 2) begin : g_chk_time
      $error("timer lengths must be at least 2");
   end

   logic [ADDR_W-1:0]       addr_lat;
   logic                    load_p, rd_p, load_acc, page_start, commit_p, toggle;
   logic                    last_d7;
   pgw_state_e              state;
   logic [PAGE_W-1:0]       page_q;
   logic [PAGE_BYTES*8-1:0] page_flat;
   logic [7:0]              arr_rd;
   logic                    busy;

   pgw_strobe #(.ADDR_W(ADDR_W)) strobe_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .addr_lat(addr_lat), .load_p(load_p), .rd_p(rd_p)
   );

   pgw_timer_ctrl #(.LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .load_p(load_p), .rd_p(rd_p), .unlock(wr_unlock),
      .state(state), .load_acc(load_acc), .page_start(page_start),
      .commit_p(commit_p), .toggle(toggle)
   );

   pgw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .USE_MASK(USE_MASK)) buf_i (
      .clk(clk), .rst_n(rst_n), .wr(load_acc), .start(page_start),
      .off(addr_lat[OFF_W-1:0]), .page_in(addr_lat[ADDR_W-1:OFF_W]), .din(dq_i),
      .page_q(page_q), .last_d7(last_d7), .page_flat(page_flat)
   );

   pgw_array #(.PAGE_BYTES(PAGE_BYTES), .MODEL_PAGES(MODEL_PAGES)) array_i (
      .clk(clk), .rst_n(rst_n), .commit(commit_p), .wr_page(page_q[MIDX_W-1:0]),
      .page_flat(page_flat), .rd_page(addr[OFF_W +: MIDX_W]),
      .rd_off(addr[OFF_W-1:0]), .rd_data(arr_rd)
   );

   assign busy  = (state != ST_IDLE);
   assign dq_en = ~ce_n & ~oe_n;
   assign dq_o  = !dq_en ? 8'h00 : busy ? {~last_d7, toggle, 6'b0} : arr_rd;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       oe_n,
   input logic       wr_unlock,
   input logic [7:0] dq_o,
   input logic       dq_en,
   input logic [1:0] state,
   input logic       load_p,
   input logic       load_acc,
   input logic       rd_p,
   input logic       toggle
);
   localparam logic [1:0] S_IDLE = 2'd0;
   localparam logic [1:0] S_LOAD = 2'd1;
   localparam logic [1:0] S_PROG = 2'd2;

   a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> (!dq_en && dq_o == 8'h00));

   a_r6_first_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && load_acc) |=> (state == S_LOAD));

   a_r7_prog_not_reopened: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PROG) |=> (state != S_LOAD));

   a_r10_locked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && load_p && !wr_unlock) |=> (state == S_IDLE));

   a_r9_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && rd_p) |=> (toggle != $past(toggle)));

   a_r9_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_en && state != S_IDLE) |-> (dq_o[5:0] == 6'b0));
endmodule

bind pgw_ctrl_top pgw_chk chk_i (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_unlock(wr_unlock),
   .dq_o(dq_o), .dq_en(dq_en), .state(state), .load_p(load_p),
   .load_acc(load_acc), .rd_p(rd_p), .toggle(toggle)
);

// File: tb/pgw_ctrl_top_tb.sv
`timescale 1ns/1ps
module pgw_ctrl_top_tb_top;
   localparam int LT = 20;
   localparam int PC = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  dq_i = '0;
   logic        wr_unlock = 1'b1;
   logic [7:0]  dq_o;
   logic        dq_en;

   int checks = 0;
   int fails  = 0;
   bit tog_m  = 1'b0;
   bit done   = 1'b0;

   logic [8:0] exp_q [$];
   string      tag_q [$];
   logic [8:0] obs;
   event       obs_ev;

   always #2.5 clk = ~clk;

   pgw_ctrl_top #(.LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_i(dq_i), .wr_unlock(wr_unlock), .dq_o(dq_o), .dq_en(dq_en)
   );

   // monitor: pops the expected item for every observed read
   initial begin
      forever begin
         @(obs_ev);
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard underflow actual=%h expected=none", obs);
         end else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (obs !== e) begin
               fails++;
               $display("FAIL %s actual en=%b dq=%h expected en=%b dq=%h",
                        t, obs[8], obs[7:0], e[8], e[7:0]);
            end
         end
      end
   end

   task automatic load_byte(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a;
      @(negedge clk); dq_i = d; we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic rd_chk(input logic [16:0] a, input logic [7:0] e, input string t);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
      #1;
      exp_q.push_back({1'b1, e}); tag_q.push_back(t);
      obs = {dq_en, dq_o}; ->obs_ev;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd_status(input bit last7, input string t);
      rd_chk(17'h0, {~last7, tog_m, 6'b0}, t);
      tog_m = ~tog_m;
   endtask

   task automatic hiz_chk(input string t);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
      #1;
      exp_q.push_back(9'h000); tag_q.push_back(t);
      obs = {dq_en, dq_o}; ->obs_ev;
      @(negedge clk); ce_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R11 reset state, R8 bus released
      rd_chk(17'h00000, 8'hFF, "R11 reset array");
      rd_chk(17'h001C5, 8'hFF, "R11 reset array page3");
      hiz_chk("R8 oe high releases bus");

      // R1 R2 R3 R5 page 1, exact end of program cycle (R6 R7)
      load_byte(17'h00083, 8'hA5);
      load_byte(17'h00085, 8'h3C);
      load_byte(17'h00083, 8'h5A);
      repeat (LT + PC) @(posedge clk);
      rd_status(1'b0, "R7 still busy on last cycle");
      rd_chk(17'h00083, 8'h5A, "R3 overwrite kept last byte");
      rd_chk(17'h00085, 8'h3C, "R2 byte stored at offset");
      rd_chk(17'h00084, 8'hFF, "R5 unloaded offset FF");
      rd_chk(17'h00080, 8'hFF, "R5 unloaded offset 0 FF");
      rd_chk(17'h00003, 8'hFF, "R1 page 0 untouched");

      // R4 target page from last byte; R9 status toggles
      load_byte(17'h00101, 8'h11);
      load_byte(17'h00182, 8'h82);
      rd_status(1'b1, "R9 status dq7 first");
      rd_status(1'b1, "R9 status toggled");
      repeat (LT + PC + 5) @(posedge clk);
      rd_chk(17'h00181, 8'h11, "R4 early byte moved to last page");
      rd_chk(17'h00182, 8'h82, "R4 last byte on last page");
      rd_chk(17'h00101, 8'hFF, "R4 earlier page untouched");
      rd_chk(17'h00083, 8'h5A, "R4 page1 keeps old data");

      // R6 re-arm, R7 load during program ignored
      load_byte(17'h00000, 8'h01);
      repeat (LT - 3) @(posedge clk);
      load_byte(17'h00001, 8'h02);
      repeat (LT + 2) @(posedge clk);
      load_byte(17'h00002, 8'h77);
      repeat (PC - 3) @(posedge clk);
      rd_status(1'b0, "R6 R7 busy until window from last load");
      rd_chk(17'h00000, 8'h01, "R6 first byte kept after re-arm");
      rd_chk(17'h00001, 8'h02, "R6 second byte");
      rd_chk(17'h00002, 8'hFF, "R7 load during program ignored");

      // R10 locked loads ignored
      wr_unlock = 1'b0;
      load_byte(17'h00087, 8'h99);
      rd_chk(17'h00087, 8'hFF, "R10 locked load not busy");
      repeat (LT + PC + 5) @(posedge clk);
      rd_chk(17'h00087, 8'hFF, "R10 locked load not committed");
      wr_unlock = 1'b1;

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule